// File: doc/BRIEF.md
# Parallel-Port Reverse Byte Sender

This block is the peripheral-side engine that streams a block of bytes back to a host over a parallel port running in its enhanced reverse mode. A start pulse loads a byte count. The block then pulls bytes from an upstream valid/ready stream and, for each byte, runs one four-step handshake with the host.

Each handshake goes like this. The byte is placed on the data lines and given a short setup time. The peripheral strobe is pulled low. The block waits for the host acknowledge to go high and then releases the strobe. It then waits for the acknowledge to fall before it fetches the next byte.

A host that answers slowly simply stalls the loop. A watchdog ends a handshake that has stalled too long: it raises an abort flag and returns the block to idle. The block has no reverse-request input, so nothing the host does can stop a block early. A block ends only when its count runs out or when the timer expires. The acknowledge line is asynchronous and passes through a two-flop synchronizer before the sequencer uses it.

Top module: `pport_rev_tx`

## Requirements
- R1: Out of reset the strobe is high, the data lines read 0, and in_ready, busy, done and abort are all low.
- R2: Bytes appear on the data lines in the order they were accepted, one byte per handshake. in_ready is high only while the block waits for the next byte of an active block.
- R3: After a byte is accepted, it stays on the data lines for SETUP_CYC cycles before the strobe falls. It is held unchanged for as long as the strobe is low.
- R4: The strobe stays low until the acknowledge goes high. With a prompt host, the strobe rises exactly three clock edges after host_ack rises: two synchronizer stages plus the state register.
- R5: After the strobe rises, no new byte is accepted until the acknowledge has been seen low.
- R6: A block with a count of N ends after exactly N handshakes. At that point done pulses high for one cycle and busy falls.
- R7: Host delays shorter than TMO_CYC, in either wait phase, only stall the transfer. The timer restarts at every handshake edge, so the total delay on one byte may exceed TMO_CYC.
- R8: A wait phase that sees no handshake edge within TMO_CYC cycles ends the block. The strobe is released high, abort is set and the block goes idle. In the wait-for-high phase the strobe is then low for exactly TMO_CYC cycles.
- R9: An acknowledge edge that reaches the sequencer in the same cycle as timer expiry wins. The block continues and does not abort.
- R10: A start while busy is ignored. A start with a count of 0 pulses done in the next cycle and sends no byte.
- R11: Abort stays high until the next start, and that start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a block (taken only when idle) |
| count_i | input | CNT_W | Number of bytes in the block |
| in_data_i | input | DATA_W | Upstream byte |
| in_valid_i | input | 1 | Upstream byte valid |
| in_ready_o | output | 1 | Block takes the upstream byte |
| host_ack_i | input | 1 | Host acknowledge line (asynchronous) |
| pd_o | output | DATA_W | Parallel data lines |
| strobe_o | output | 1 | Peripheral strobe (idle high, low = byte presented) |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | One-cycle pulse when a block completes |
| abort_o | output | 1 | Timeout abort flag, held until next start |

## Verification
The timer can expire in the same cycle that the synchronized acknowledge first shows high, and the two outcomes differ by a single cycle. The bench provokes this by raising host_ack exactly TMO_CYC-3 cycles after it first sees the strobe low, which puts the synchronized edge in the last counted cycle. In that case the transfer must finish with abort low. Raising host_ack one cycle later must abort the block. In both cases the strobe low time is measured and must equal TMO_CYC.

// File: rtl/pport_rev_pkg.sv
package pport_rev_pkg;
    typedef enum logic [2:0] {
        RS_IDLE,
        RS_FETCH,
        RS_SETUP,
        RS_ACKHI,
        RS_ACKLO
    } rtx_state_e;
endpackage

// File: rtl/pport_sync2.sv
module pport_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [1:0] sr_d, sr_q;

    always_comb begin
        sr_d = {sr_q[0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign q_o = sr_q[1];
endmodule

// File: rtl/pport_rev_wdog.sv
module pport_rev_wdog #(
    parameter int LIMIT = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic kick_i,
    output logic expired_o
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i || kick_i)  cnt_d = '0;
        else if (cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/pport_rev_fsm.sv
module pport_rev_fsm
    import pport_rev_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 16,
    parameter int SETUP_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic              ack_s_i,
    input  logic              tmo_i,
    output logic              run_o,
    output logic              kick_o,
    output logic [DATA_W-1:0] pd_o,
    output logic              strobe_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              abort_o
);
    localparam int SET_W = $clog2(SETUP_CYC + 1);
    localparam logic [SET_W-1:0] SETUP_LAST = SET_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        rtx_state_e        st;
        logic [CNT_W-1:0]  left;
        logic [SET_W-1:0]  setup;
        logic [DATA_W-1:0] data;
        logic              strobe;
        logic              done;
        logic              abort;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        kick_o   = 1'b0;
        case (r_q.st)
            RS_IDLE: begin
                if (start_i) begin
                    r_d.abort = 1'b0;
                    if (count_i == '0) begin
                        r_d.done = 1'b1;
                    end else begin
                        r_d.left = count_i;
                        r_d.st   = RS_FETCH;
                    end
                end
            end
            RS_FETCH: begin
                if (in_valid_i) begin
                    r_d.data  = in_data_i;
                    r_d.setup = '0;
                    r_d.st    = RS_SETUP;
                end
            end
            RS_SETUP: begin
                if (r_q.setup == SETUP_LAST) begin
                    r_d.strobe = 1'b0;
                    r_d.st     = RS_ACKHI;
                end else begin
                    r_d.setup = r_q.setup + 1'b1;
                end
            end
            RS_ACKHI: begin
                if (ack_s_i) begin
                    kick_o     = 1'b1;
                    r_d.strobe = 1'b1;
                    r_d.st     = RS_ACKLO;
                end else if (tmo_i) begin
                    r_d.strobe = 1'b1;
                    r_d.abort  = 1'b1;
                    r_d.st     = RS_IDLE;
                end
            end
            RS_ACKLO: begin
                if (!ack_s_i) begin
                    kick_o   = 1'b1;
                    r_d.left = r_q.left - 1'b1;
                    if (r_q.left == ONE) begin
                        r_d.done = 1'b1;
                        r_d.st   = RS_IDLE;
                    end else begin
                        r_d.st = RS_FETCH;
                    end
                end else if (tmo_i) begin
                    r_d.abort = 1'b1;
                    r_d.st    = RS_IDLE;
                end
            end
            default: r_d.st = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= RS_IDLE;
            r_q.left   <= '0;
            r_q.setup  <= '0;
            r_q.data   <= '0;
            r_q.strobe <= 1'b1;
            r_q.done   <= 1'b0;
            r_q.abort  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready_o = (r_q.st == RS_FETCH);
    assign run_o      = (r_q.st == RS_ACKHI) || (r_q.st == RS_ACKLO);
    assign busy_o     = (r_q.st != RS_IDLE);
    assign pd_o       = r_q.data;
    assign strobe_o   = r_q.strobe;
    assign done_o     = r_q.done;
    assign abort_o    = r_q.abort;
endmodule

// File: rtl/pport_rev_tx.sv
module pport_rev_tx #(
    parameter int DATA_W    = 8,
    parameter int CNT_W     = 16,
    parameter int SETUP_CYC = 2,
    parameter int TMO_CYC   = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [DATA_W-1:0] in_data_i,
    input  logic              in_valid_i,
    output logic              in_ready_o,
    input  logic              host_ack_i,
    output logic [DATA_W-1:0] pd_o,
    output logic              strobe_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              abort_o
);
    logic ack_s, tmo, run, kick;

    pport_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (host_ack_i),
        .q_o   (ack_s)
    );

    pport_rev_wdog #(.LIMIT(TMO_CYC)) u_wdog (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .kick_i    (kick),
        .expired_o (tmo)
    );

    pport_rev_fsm #(
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .SETUP_CYC (SETUP_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .count_i    (count_i),
        .in_data_i  (in_data_i),
        .in_valid_i (in_valid_i),
        .in_ready_o (in_ready_o),
        .ack_s_i    (ack_s),
        .tmo_i      (tmo),
        .run_o      (run),
        .kick_o     (kick),
        .pd_o       (pd_o),
        .strobe_o   (strobe_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .abort_o    (abort_o)
    );
endmodule

// File: rtl/pport_rev_tx_chk.sv
module pport_rev_tx_chk #(
    parameter int DATA_W    = 8,
    parameter int SETUP_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              in_ready_o,
    input logic              host_ack_i,
    input logic [DATA_W-1:0] pd_o,
    input logic              strobe_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              abort_o
);
    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_o |=> $stable(pd_o));

    generate
        if (SETUP_CYC >= 2) begin : g_setup
            // R3
            setup_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(strobe_o) |-> ($stable(pd_o) && ($past(pd_o, 1) == $past(pd_o, 2))));
        end
    endgenerate

    // R5
    ready_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> strobe_o);

    // R4
    rise_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(strobe_o) && !$rose(abort_o)) |-> $past(host_ack_i, 3));

    // R6
    end_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o ^ abort_o));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(abort_o) |-> (strobe_o && !busy_o && !in_ready_o));

    // R11
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_o && !start_i) |=> abort_o);
endmodule

bind pport_rev_tx pport_rev_tx_chk #(
    .DATA_W    (DATA_W),
    .SETUP_CYC (SETUP_CYC)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .in_ready_o (in_ready_o),
    .host_ack_i (host_ack_i),
    .pd_o       (pd_o),
    .strobe_o   (strobe_o),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .abort_o    (abort_o)
);

// File: tb/pport_rev_tx_bench.sv
`timescale 1ns/1ps
module pport_rev_tx_bench;
    localparam int DW  = 8;
    localparam int CW  = 8;
    localparam int SET = 2;
    localparam int TMO = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [CW-1:0] count_i = '0;
    logic [DW-1:0] in_data_i = '0;
    logic          in_valid_i = 1'b0;
    logic          in_ready_o;
    logic          host_ack_i = 1'b0;
    logic [DW-1:0] pd_o;
    logic          strobe_o, busy_o, done_o, abort_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;
    int  dly_hi = 0;
    int  dly_lo = 0;
    bit  chk_rise = 1'b1;
    int  n_bytes = 0;
    int  low_run = 0;
    int  last_low = 0;
    logic [DW-1:0] exp_q[$];

    always #2.5 clk = ~clk;

    pport_rev_tx #(
        .DATA_W (DW), .CNT_W (CW), .SETUP_CYC (SET), .TMO_CYC (TMO)
    ) u_pport_rev_tx (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .count_i (count_i),
        .in_data_i (in_data_i), .in_valid_i (in_valid_i), .in_ready_o (in_ready_o),
        .host_ack_i (host_ack_i), .pd_o (pd_o), .strobe_o (strobe_o),
        .busy_o (busy_o), .done_o (done_o), .abort_o (abort_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // strobe low-time measurement (R8, R9)
    always @(negedge clk) begin
        if (rst_n && strobe_o === 1'b0) low_run <= low_run + 1;
        else if (low_run != 0) begin
            last_low <= low_run;
            low_run  <= 0;
        end
    end

    // monitor: acts as host and scoreboards data (R2, R4, R5)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && strobe_o === 1'b0) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected byte", int'(pd_o), -1);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(pd_o == e, "R2 byte order", int'(pd_o), int'(e));
                end
                n_bytes++;
                repeat (dly_hi) @(negedge clk);
                host_ack_i = 1'b1;
                begin
                    int n;
                    bit rdy_seen;
                    n = 0;
                    while (!strobe_o && n < 500) begin
                        @(negedge clk);
                        n++;
                    end
                    if (chk_rise) chk(n == 3, "R4 strobe rise latency", n, 3);
                    rdy_seen = 1'b0;
                    for (int k = 0; k < dly_lo; k++) begin
                        @(negedge clk);
                        if (in_ready_o) rdy_seen = 1'b1;
                    end
                    chk(!rdy_seen, "R5 no fetch while ack high", int'(rdy_seen), 0);
                end
                host_ack_i = 1'b0;
            end
        end
    end

    task automatic start_blk(input int n);
        @(negedge clk);
        start_i = 1'b1;
        count_i = CW'(n);
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic feed(input int n, input int base, input int gap);
        for (int i = 0; i < n; i++) begin
            int g;
            if (gap > 0) repeat (gap) @(negedge clk);
            in_data_i  = DW'(base + i * 37);
            in_valid_i = 1'b1;
            g = 0;
            while (!in_ready_o && !abort_o && g < 1000) begin
                @(negedge clk);
                g++;
            end
            if (abort_o || !in_ready_o) begin
                in_valid_i = 1'b0;
                break;
            end
            exp_q.push_back(DW'(base + i * 37));
            @(negedge clk);
            in_valid_i = 1'b0;
        end
    endtask

    task automatic wait_end(output bit was_done);
        int g;
        g = 0;
        while (!done_o && !abort_o && g < 2000) begin
            @(negedge clk);
            g++;
        end
        was_done = done_o;
    endtask

    initial begin
        bit d;
        int b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(strobe_o == 1'b1, "R1 strobe idle", int'(strobe_o), 1);
        chk(pd_o == '0, "R1 data reset", int'(pd_o), 0);
        chk(!in_ready_o && !busy_o && !done_o && !abort_o, "R1 flags low",
            int'({in_ready_o, busy_o, done_o, abort_o}), 0);

        // R2 R3 R6: prompt host, back-to-back bytes
        b0 = n_bytes;
        start_blk(4);
        chk(in_ready_o && busy_o, "R2 ready after start", int'(in_ready_o), 1);
        feed(4, 8'h11, 0);
        wait_end(d);
        chk(d, "R6 done after count", int'(d), 1);
        chk(n_bytes - b0 == 4, "R6 byte count", n_bytes - b0, 4);
        @(negedge clk);
        chk(!done_o && !busy_o, "R6 done one cycle", int'(done_o), 0);
        chk(exp_q.size() == 0, "R2 all bytes seen", exp_q.size(), 0);

        // R7: slow host in both phases, gaps upstream
        dly_hi = 11; dly_lo = 11;
        b0 = n_bytes;
        start_blk(3);
        feed(3, 8'hA0, 5);
        wait_end(d);
        chk(d && !abort_o, "R7 slow host no abort", int'(abort_o), 0);
        chk(n_bytes - b0 == 3, "R7 byte count", n_bytes - b0, 3);
        dly_hi = 0; dly_lo = 0;
        repeat (20) @(negedge clk);

        // R10: zero count
        b0 = n_bytes;
        start_blk(0);
        chk(done_o && !busy_o, "R10 zero count done", int'(done_o), 1);
        repeat (10) @(negedge clk);
        chk(n_bytes == b0 && strobe_o, "R10 zero count no byte", n_bytes - b0, 0);

        // R10: start while busy ignored
        b0 = n_bytes;
        start_blk(2);
        fork
            feed(2, 8'h5C, 0);
            begin
                repeat (4) @(negedge clk);
                start_i = 1'b1;
                count_i = CW'(5);
                @(negedge clk);
                start_i = 1'b0;
            end
        join
        wait_end(d);
        repeat (30) @(negedge clk);
        chk(n_bytes - b0 == 2 && !busy_o, "R10 busy start ignored", n_bytes - b0, 2);

        // R9: ack reaches sequencer in the expiry cycle
        dly_hi = TMO - 3;
        b0 = n_bytes;
        start_blk(1);
        feed(1, 8'h3E, 0);
        wait_end(d);
        chk(d && !abort_o, "R9 ack wins over expiry", int'(abort_o), 0);
        chk(last_low == TMO, "R9 strobe low time", last_low, TMO);
        repeat (10) @(negedge clk);

        // R8: wait-for-high timeout
        dly_hi = TMO - 2; chk_rise = 1'b0;
        start_blk(3);
        feed(3, 8'h70, 0);
        wait_end(d);
        chk(abort_o && !d, "R8 abort on high-wait", int'(abort_o), 1);
        @(negedge clk);
        chk(strobe_o && !busy_o && !in_ready_o, "R8 idle after abort", int'(busy_o), 0);
        chk(last_low == TMO, "R8 strobe low time", last_low, TMO);
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R8 no further byte", exp_q.size(), 0);
        chk(abort_o, "R11 abort held", int'(abort_o), 1);

        // R8: wait-for-low timeout
        dly_hi = 0; dly_lo = 25; chk_rise = 1'b1;
        start_blk(2);
        chk(!abort_o, "R11 start clears abort", int'(abort_o), 0);
        feed(2, 8'hC3, 0);
        wait_end(d);
        chk(abort_o && !d, "R8 abort on low-wait", int'(abort_o), 1);
        repeat (40) @(negedge clk);
        chk(abort_o && !busy_o, "R11 abort kept", int'(abort_o), 1);

        // recovery after abort
        dly_lo = 0;
        b0 = n_bytes;
        start_blk(2);
        chk(!abort_o, "R11 cleared on start", int'(abort_o), 0);
        feed(2, 8'h09, 0);
        wait_end(d);
        chk(d && n_bytes - b0 == 2, "R6 block after abort", n_bytes - b0, 2);
        repeat (5) @(negedge clk);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule